// File: doc/BRIEF.md
# Bus-Matching Width Converter

This block sits between a FIFO that stores 36-bit long words and an external port whose width is chosen at master reset: the full 36 bits, an 18-bit word or a 9-bit byte. In the write direction, the port presents pieces that the block gathers into one long word, which it pushes into the FIFO together with the last piece. In the read direction, the block pops one long word and hands it to the port as one, two or four successive pieces. Big-endian or little-endian piece order can be selected for the two narrow widths.

Two small state machines do the work. The gathering side (`bm_pack`) has the states PK_EMPTY (no piece held) and PK_PARTIAL (some pieces held). A non-final piece accepted in PK_EMPTY moves it to PK_PARTIAL. The final piece accepted in PK_PARTIAL returns it to PK_EMPTY. In 36-bit mode every piece is final, so the machine stays in PK_EMPTY. The splitting side (`bm_unpack`) has the states UP_IDLE (no word held) and UP_SEND (a word is being handed out). An available word moves it from UP_IDLE to UP_SEND. When the final piece is accepted in UP_SEND, it loads the next word and stays in UP_SEND if one is available, and otherwise returns to UP_IDLE. Either reset forces both machines into PK_EMPTY and UP_IDLE.

Two resets exist. The master reset also samples the width and order configuration. The partial reset clears data and piece position and keeps the configuration.

Top module: `bm_width_conv`

## Requirements
- R1: With bm_sel low the port is 36 bits wide and each transfer carries a whole word. With bm_sel high and size_sel low it is 18 bits wide (data on bits 17:0, two pieces per word). With bm_sel high and size_sel high it is 9 bits wide (data on bits 8:0, four pieces per word).
- R2: With endian_sel low (big-endian), the first piece of a narrow transfer is the most significant part of the word (bits 35:18 for 18-bit, bits 35:27 for 9-bit), and the pieces follow in descending significance.
- R3: With endian_sel high (little-endian), the first piece is the least significant part (bits 17:0 or 8:0), and the pieces follow in ascending significance.
- R4: In 36-bit mode endian_sel has no effect, and a word passes unchanged in both directions.
- R5: bm_sel, size_sel and endian_sel are sampled on every clock edge while mrst_n is low. Changing them while mrst_n is high has no effect.
- R6: push_valid is high only while in_valid presents the final piece of a word, and push_data then equals the completed word. Non-final pieces are accepted (in_ready high) whatever the state of push_ready. The final piece is accepted only while push_ready is high.
- R7: pop_ready is high only when no word is held, or when the final piece of the held word is being accepted (out_valid and out_ready both high). A held word is never replaced before all of its pieces have been accepted.
- R8: In narrow modes, input bits above the active lane are ignored, and out_data bits above the active lane are driven to zero.
- R9: A low prst_n clears the piece position, any partly gathered word and any held read word, and keeps the configuration. After either reset, out_valid and push_valid are low and pop_ready and in_ready (narrow modes) are high.
- R10: out_valid stays high from the first piece through the last piece, and stays high across back-to-back words with no idle cycle. It falls only after the final piece is accepted while no further word is available. out_data is stable while out_valid is high and out_ready is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst_n | input | 1 | Master reset, active low, synchronous. Samples the configuration |
| prst_n | input | 1 | Partial reset, active low, synchronous. Keeps the configuration |
| bm_sel | input | 1 | Low: 36-bit port. High: narrow port |
| size_sel | input | 1 | Narrow width: low for 18-bit, high for 9-bit |
| endian_sel | input | 1 | Low: big-endian piece order. High: little-endian |
| in_valid | input | 1 | Port write piece valid |
| in_ready | output | 1 | Port write piece accepted |
| in_data | input | 36 | Port write piece, in the low lanes when narrow |
| push_valid | output | 1 | Completed word offered to the FIFO |
| push_ready | input | 1 | FIFO can take a word (not full) |
| push_data | output | 36 | Completed word |
| pop_valid | input | 1 | FIFO holds a word (not empty) |
| pop_ready | output | 1 | Block takes the FIFO head word this cycle |
| pop_data | input | 36 | FIFO head word |
| out_valid | output | 1 | Port read piece valid |
| out_ready | input | 1 | Port read piece accepted |
| out_data | output | 36 | Port read piece, in the low lanes when narrow, with the upper bits zero |

## Verification
The hardest case to reach from the ports is a final write piece that the FIFO holds off. The stimulus must gather the first pieces, lower push_ready, and then hold the final piece while checking that in_ready stays low, that push_valid stays high and that no second push follows once push_ready rises. A similar case exists on the read side. The bench loads two words into its FIFO model while out_ready is low, checks that pop_ready stays low and that the first piece does not change, and then releases the port so that the second word follows without a gap. A partial reset pulse between gathered pieces shows that the piece position is cleared: the next push comes only after a full set of pieces in the still-active width.

// File: rtl/bm_pkg.sv
package bm_pkg;

    typedef enum logic [1:0] {
        BM_LONG = 2'd0,
        BM_WORD = 2'd1,
        BM_BYTE = 2'd2
    } bm_width_e;

    typedef struct packed {
        bm_width_e width;
        logic      little;
    } bm_cfg_t;

    typedef enum logic {
        PK_EMPTY,
        PK_PARTIAL
    } pk_state_e;

    typedef enum logic {
        UP_IDLE,
        UP_SEND
    } up_state_e;

    // index of the final piece for a width
    function automatic logic [1:0] bm_last_idx(input bm_width_e w);
        logic [1:0] r;
        unique case (w)
            BM_LONG: r = 2'd0;
            BM_WORD: r = 2'd1;
            BM_BYTE: r = 2'd3;
            default: r = 2'd0;
        endcase
        return r;
    endfunction

    // lane carrying piece idx under the chosen order
    function automatic logic [1:0] bm_lane(input bm_width_e w, input logic little,
                                           input logic [1:0] idx);
        logic [1:0] last;
        last = bm_last_idx(w);
        return little ? idx : (last - idx);
    endfunction

endpackage

// File: rtl/bm_cfg_latch.sv
module bm_cfg_latch
    import bm_pkg::*;
(
    input  logic    clk,
    input  logic    mrst_n,
    input  logic    bm_sel,
    input  logic    size_sel,
    input  logic    endian_sel,
    output bm_cfg_t cfg
);

    bm_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (!mrst_n) begin
            if (!bm_sel)       cfg_q.width <= BM_LONG;
            else if (size_sel) cfg_q.width <= BM_BYTE;
            else               cfg_q.width <= BM_WORD;
            cfg_q.little <= endian_sel;
        end
    end

    assign cfg = cfg_q;

    // R5: configuration frozen outside master reset
    p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!mrst_n)
        $past(mrst_n) |-> $stable(cfg_q))
        else $error("R5 configuration changed outside master reset");

endmodule

// File: rtl/bm_pack.sv
module bm_pack
    import bm_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrst_n,
    input  bm_cfg_t           cfg,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              push_valid,
    input  logic              push_ready,
    output logic [DATA_W-1:0] push_data
);

    localparam int HALF_W = DATA_W / 2;
    localparam int QTR_W  = DATA_W / 4;

    pk_state_e         state_q, state_d;
    logic [1:0]        idx_q, idx_d;
    logic [DATA_W-1:0] asm_q, asm_d;
    logic [DATA_W-1:0] merged;
    logic [1:0]        last, lane;
    logic              is_last, fire;

    logic [HALF_W-1:0] mh [2];
    logic [QTR_W-1:0]  mq [4];

    assign last    = bm_last_idx(cfg.width);
    assign lane    = bm_lane(cfg.width, cfg.little, idx_q);
    assign is_last = (idx_q == last);

    // drop the incoming piece into its lane, keep the others
    for (genvar h = 0; h < 2; h++) begin : g_half
        assign mh[h] = (lane[0] == 1'(h)) ? in_data[HALF_W-1:0]
                                          : asm_q[h*HALF_W +: HALF_W];
    end
    for (genvar q = 0; q < 4; q++) begin : g_qtr
        assign mq[q] = (lane == 2'(q)) ? in_data[QTR_W-1:0]
                                       : asm_q[q*QTR_W +: QTR_W];
    end

    always_comb begin
        unique case (cfg.width)
            BM_LONG: merged = in_data;
            BM_WORD: merged = {mh[1], mh[0]};
            BM_BYTE: merged = {mq[3], mq[2], mq[1], mq[0]};
            default: merged = in_data;
        endcase
    end

    // outputs
    always_comb begin
        in_ready   = !rst && (!is_last || push_ready);
        push_valid = !rst && in_valid && is_last;
        push_data  = merged;
    end

    assign fire = in_valid && in_ready;

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        asm_d   = asm_q;
        unique case (state_q)
            PK_EMPTY: begin
                if (fire && !is_last) begin
                    state_d = PK_PARTIAL;
                    idx_d   = idx_q + 2'd1;
                    asm_d   = merged;
                end
            end
            PK_PARTIAL: begin
                if (fire) begin
                    asm_d = merged;
                    if (is_last) begin
                        state_d = PK_EMPTY;
                        idx_d   = 2'd0;
                    end else begin
                        idx_d = idx_q + 2'd1;
                    end
                end
            end
            default: state_d = PK_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PK_EMPTY;
            idx_q   <= 2'd0;
            asm_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            asm_q   <= asm_d;
        end
    end

    // R1: piece position never passes the final piece of the width
    p_pos_range_r1: assert property (@(posedge clk) disable iff (rst)
        idx_q <= last)
        else $error("R1 piece position out of range");

    // R6: a completed push leaves the gatherer empty
    p_push_clears_r6: assert property (@(posedge clk) disable iff (rst)
        push_valid && push_ready |=> (state_q == PK_EMPTY) && (idx_q == 2'd0))
        else $error("R6 gatherer not empty after push");

    // R6: a refused piece does not advance the position
    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && !in_ready |=> $stable(idx_q))
        else $error("R6 position moved on a refused piece");

    // R9: partial reset leaves the gatherer empty
    p_prst_empty_r9: assert property (@(posedge clk) disable iff (!mrst_n)
        rst |=> (state_q == PK_EMPTY) && (idx_q == 2'd0))
        else $error("R9 gatherer not cleared by reset");

endmodule

// File: rtl/bm_unpack.sv
module bm_unpack
    import bm_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mrst_n,
    input  bm_cfg_t           cfg,
    input  logic              pop_valid,
    output logic              pop_ready,
    input  logic [DATA_W-1:0] pop_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    localparam int HALF_W = DATA_W / 2;
    localparam int QTR_W  = DATA_W / 4;

    up_state_e         state_q, state_d;
    logic [1:0]        idx_q, idx_d;
    logic [DATA_W-1:0] hold_q, hold_d;
    logic [1:0]        last, lane;
    logic              is_last, take;

    logic [HALF_W-1:0] hh [2];
    logic [QTR_W-1:0]  hq [4];

    assign last    = bm_last_idx(cfg.width);
    assign lane    = bm_lane(cfg.width, cfg.little, idx_q);
    assign is_last = (idx_q == last);

    for (genvar h = 0; h < 2; h++) begin : g_half
        assign hh[h] = hold_q[h*HALF_W +: HALF_W];
    end
    for (genvar q = 0; q < 4; q++) begin : g_qtr
        assign hq[q] = hold_q[q*QTR_W +: QTR_W];
    end

    // outputs
    always_comb begin
        out_valid = (state_q == UP_SEND);
        pop_ready = !rst && ((state_q == UP_IDLE) || (out_ready && is_last));
        unique case (cfg.width)
            BM_LONG: out_data = hold_q;
            BM_WORD: out_data = {{(DATA_W-HALF_W){1'b0}}, hh[lane[0]]};
            BM_BYTE: out_data = {{(DATA_W-QTR_W){1'b0}}, hq[lane]};
            default: out_data = hold_q;
        endcase
    end

    assign take = pop_valid && pop_ready;

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        hold_d  = hold_q;
        unique case (state_q)
            UP_IDLE: begin
                if (take) begin
                    state_d = UP_SEND;
                    idx_d   = 2'd0;
                    hold_d  = pop_data;
                end
            end
            UP_SEND: begin
                if (out_ready) begin
                    if (!is_last) begin
                        idx_d = idx_q + 2'd1;
                    end else if (take) begin
                        idx_d  = 2'd0;
                        hold_d = pop_data;
                    end else begin
                        state_d = UP_IDLE;
                        idx_d   = 2'd0;
                    end
                end
            end
            default: state_d = UP_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= UP_IDLE;
            idx_q   <= 2'd0;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            hold_q  <= hold_d;
        end
    end

    // R7: a stalled piece never lets the FIFO pop
    p_no_early_pop_r7: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |-> !pop_ready)
        else $error("R7 pop while a word is still held");

    // R10: a stalled piece stays on the port
    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        out_valid && !out_ready |=> out_valid && $stable(out_data))
        else $error("R10 output changed while stalled");

    // R8: upper lanes are zero in narrow modes
    p_pad_zero_r8: assert property (@(posedge clk) disable iff (rst)
        out_valid && (cfg.width != BM_LONG) |-> out_data[DATA_W-1:HALF_W] == '0)
        else $error("R8 unused output lanes not zero");

    // R9: reset drops any held word
    p_prst_clears_r9: assert property (@(posedge clk) disable iff (!mrst_n)
        rst |=> !out_valid)
        else $error("R9 held word survived reset");

endmodule

// File: rtl/bm_width_conv.sv
module bm_width_conv
    import bm_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  logic              clk,
    input  logic              mrst_n,
    input  logic              prst_n,
    input  logic              bm_sel,
    input  logic              size_sel,
    input  logic              endian_sel,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [DATA_W-1:0] in_data,
    output logic              push_valid,
    input  logic              push_ready,
    output logic [DATA_W-1:0] push_data,
    input  logic              pop_valid,
    output logic              pop_ready,
    input  logic [DATA_W-1:0] pop_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    bm_cfg_t cfg;
    logic    rst;

    assign rst = !mrst_n || !prst_n;

    bm_cfg_latch u_cfg (
        .clk        (clk),
        .mrst_n     (mrst_n),
        .bm_sel     (bm_sel),
        .size_sel   (size_sel),
        .endian_sel (endian_sel),
        .cfg        (cfg)
    );

    bm_pack #(.DATA_W(DATA_W)) u_pack (
        .clk        (clk),
        .rst        (rst),
        .mrst_n     (mrst_n),
        .cfg        (cfg),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_data    (in_data),
        .push_valid (push_valid),
        .push_ready (push_ready),
        .push_data  (push_data)
    );

    bm_unpack #(.DATA_W(DATA_W)) u_unpack (
        .clk       (clk),
        .rst       (rst),
        .mrst_n    (mrst_n),
        .cfg       (cfg),
        .pop_valid (pop_valid),
        .pop_ready (pop_ready),
        .pop_data  (pop_data),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_data  (out_data)
    );

endmodule

// File: tb/tb_bm_width_conv.sv
module tb_bm_width_conv;

    logic        clk = 1'b0;
    logic        mrst_n = 1'b0, prst_n = 1'b1;
    logic        bm_sel = 1'b0, size_sel = 1'b0, endian_sel = 1'b0;
    logic        in_valid = 1'b0, in_ready;
    logic [35:0] in_data = '0;
    logic        push_valid, push_ready = 1'b1;
    logic [35:0] push_data;
    logic        pop_valid, pop_ready;
    logic [35:0] pop_data;
    logic        out_valid, out_ready = 1'b0;
    logic [35:0] out_data;

    // FIFO model feeding the read side
    logic [35:0] src_mem [16];
    logic [7:0]  src_rd = '0, src_wr = '0;

    int vec = 0, fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    assign pop_valid = (src_rd != src_wr);
    assign pop_data  = src_mem[src_rd[3:0]];

    always @(posedge clk) if (pop_valid && pop_ready) src_rd <= src_rd + 8'd1;

    bm_width_conv dut (
        .clk(clk), .mrst_n(mrst_n), .prst_n(prst_n),
        .bm_sel(bm_sel), .size_sel(size_sel), .endian_sel(endian_sel),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .push_valid(push_valid), .push_ready(push_ready), .push_data(push_data),
        .pop_valid(pop_valid), .pop_ready(pop_ready), .pop_data(pop_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic chk(input string tag, input logic [35:0] act, input logic [35:0] exp);
        vec++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int n_pieces(input int mode);
        return (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
    endfunction

    // mode 0 = 36-bit, 1 = 18-bit, 2 = 9-bit
    function automatic logic [35:0] piece_of(input logic [35:0] w, input int mode,
                                             input bit le, input int i);
        int n, pw, lane;
        n    = n_pieces(mode);
        pw   = 36 / n;
        lane = le ? i : n - 1 - i;
        if (mode == 0) return w;
        return (w >> (lane * pw)) & ((36'd1 << pw) - 36'd1);
    endfunction

    function automatic logic [35:0] junk_of(input int mode);
        int pw;
        pw = 36 / n_pieces(mode);
        if (mode == 0) return '0;
        return ~((36'd1 << pw) - 36'd1);
    endfunction

    task automatic do_mreset(input int mode, input bit le);
        @(negedge clk);
        mrst_n = 1'b0; prst_n = 1'b1;
        bm_sel = (mode != 0); size_sel = (mode == 2); endian_sel = le;
        in_valid = 1'b0; out_ready = 1'b0; push_ready = 1'b1;
        repeat (2) @(negedge clk);
        mrst_n = 1'b1;
    endtask

    task automatic wr_piece(input logic [35:0] d, input logic exp_ready, input logic exp_push,
                            input logic [35:0] exp_word, input string req);
        @(negedge clk);
        in_data = d; in_valid = 1'b1;
        #1;
        chk({req, " in_ready"}, 36'(in_ready), 36'(exp_ready));
        chk({req, " push_valid"}, 36'(push_valid), 36'(exp_push));
        if (exp_push) chk({req, " push_data"}, push_data, exp_word);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic write_word(input int mode, input bit le, input logic [35:0] w,
                              input string req);
        int n;
        n = n_pieces(mode);
        for (int i = 0; i < n; i++)
            wr_piece(piece_of(w, mode, le, i) | junk_of(mode), 1'b1, (i == n - 1), w, req);
    endtask

    task automatic read_words(input int mode, input bit le, input logic [35:0] w0,
                              input logic [35:0] w1, input string req);
        logic [35:0] ws [2];
        ws[0] = w0; ws[1] = w1;
        @(negedge clk);
        out_ready = 1'b1;
        src_mem[src_wr[3:0]] = w0; src_wr = src_wr + 8'd1;
        src_mem[src_wr[3:0]] = w1; src_wr = src_wr + 8'd1;
        @(posedge clk);
        for (int k = 0; k < 2; k++) begin
            for (int i = 0; i < n_pieces(mode); i++) begin
                @(negedge clk);
                chk({req, " R10 out_valid streaming"}, 36'(out_valid), 36'd1);
                chk({req, " out_data"}, out_data, piece_of(ws[k], mode, le, i));
            end
        end
        @(negedge clk);
        chk({req, " R10 out_valid after drain"}, 36'(out_valid), 36'd0);
        out_ready = 1'b0;
    endtask

    // R9: reset state
    task automatic t_reset_state();
        do_mreset(1, 1'b0);
        #1;
        chk("R9 out_valid after reset", 36'(out_valid), 36'd0);
        chk("R9 push_valid after reset", 36'(push_valid), 36'd0);
        chk("R9 pop_ready after reset", 36'(pop_ready), 36'd1);
        chk("R9 in_ready after reset", 36'(in_ready), 36'd1);
    endtask

    // R1 R2 R3 R4 R8: gathering in every width and order
    task automatic t_write_modes();
        for (int m = 0; m < 3; m++) begin
            for (int e = 0; e < 2; e++) begin
                do_mreset(m, e[0]);
                write_word(m, e[0], 36'h9_1234_5678 ^ 36'(m * 3 + e),
                           (m == 0) ? "R4 write" : (e == 0) ? "R1 R2 R8 write" : "R1 R3 R8 write");
            end
        end
    endtask

    // R1 R2 R3 R4 R8 R10: splitting in every width and order
    task automatic t_read_modes();
        for (int m = 0; m < 3; m++) begin
            for (int e = 0; e < 2; e++) begin
                do_mreset(m, e[0]);
                read_words(m, e[0], 36'hA_BCDE_F012 ^ 36'(m + e), 36'h1_3579_BDF0,
                           (m == 0) ? "R4 read" : (e == 0) ? "R1 R2 R8 read" : "R1 R3 R8 read");
            end
        end
    endtask

    // R5: configuration ignored after master reset is released
    task automatic t_cfg_frozen();
        do_mreset(2, 1'b1);
        @(negedge clk);
        bm_sel = 1'b0; size_sel = 1'b0; endian_sel = 1'b0;
        write_word(2, 1'b1, 36'h8_7654_3210, "R5 write keeps byte order");
        read_words(2, 1'b1, 36'h2_468A_CE13, 36'h0_FEDC_BA98, "R5 read keeps byte order");
    endtask

    // R6: final piece held off by a full FIFO
    task automatic t_write_stall();
        logic [35:0] w;
        w = 36'hC_0FFE_E123;
        do_mreset(1, 1'b0);
        push_ready = 1'b0;
        wr_piece(piece_of(w, 1, 1'b0, 0), 1'b1, 1'b0, w, "R6 first piece while full");
        @(negedge clk);
        in_data = piece_of(w, 1, 1'b0, 1); in_valid = 1'b1;
        #1;
        chk("R6 final piece refused", 36'(in_ready), 36'd0);
        chk("R6 push offered", 36'(push_valid), 36'd1);
        @(negedge clk);
        chk("R6 still refused", 36'(in_ready), 36'd0);
        push_ready = 1'b1;
        #1;
        chk("R6 accepted when not full", 36'(in_ready), 36'd1);
        chk("R6 push_data after stall", push_data, w);
        @(posedge clk);
        #1 in_valid = 1'b0;
        @(negedge clk);
        chk("R6 no second push", 36'(push_valid), 36'd0);
        write_word(1, 1'b0, 36'h3_3333_CCCC, "R6 next word");
    endtask

    // R7 R10: port stalls while a word is held
    task automatic t_read_stall();
        logic [35:0] w0, w1;
        w0 = 36'h5_A5A5_0F0F; w1 = 36'h6_1122_3344;
        do_mreset(2, 1'b0);
        @(negedge clk);
        src_mem[src_wr[3:0]] = w0; src_wr = src_wr + 8'd1;
        src_mem[src_wr[3:0]] = w1; src_wr = src_wr + 8'd1;
        @(posedge clk);
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk("R10 stalled piece present", 36'(out_valid), 36'd1);
            chk("R10 stalled piece stable", out_data, piece_of(w0, 2, 1'b0, 0));
            chk("R7 no pop while held", 36'(pop_ready), 36'd0);
        end
        out_ready = 1'b1;
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            chk("R10 piece after stall", out_data, piece_of(w0, 2, 1'b0, i));
            chk("R7 pop only on final piece", 36'(pop_ready), 36'(i == 3));
        end
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk("R10 second word no gap", 36'(out_valid), 36'd1);
            chk("R7 second word data", out_data, piece_of(w1, 2, 1'b0, i));
        end
        @(negedge clk);
        chk("R10 empty after drain", 36'(out_valid), 36'd0);
        out_ready = 1'b0;
    endtask

    // R9: partial reset mid-word keeps configuration
    task automatic t_partial();
        logic [35:0] x;
        x = 36'hF_EDCB_A987;
        do_mreset(2, 1'b1);
        wr_piece(piece_of(x, 2, 1'b1, 0), 1'b1, 1'b0, x, "R9 partial piece");
        wr_piece(piece_of(x, 2, 1'b1, 1), 1'b1, 1'b0, x, "R9 partial piece");
        @(negedge clk); prst_n = 1'b0;
        @(negedge clk); prst_n = 1'b1;
        write_word(2, 1'b1, 36'h1_2233_4455, "R9 position cleared, width kept");
        @(negedge clk);
        src_mem[src_wr[3:0]] = 36'h7_0000_0001; src_wr = src_wr + 8'd1;
        @(posedge clk);
        @(negedge clk);
        chk("R9 word held before reset", 36'(out_valid), 36'd1);
        prst_n = 1'b0;
        @(negedge clk);
        prst_n = 1'b1;
        #1;
        chk("R9 held word dropped", 36'(out_valid), 36'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
            $finish;
        end
    end

    initial begin
        t_reset_state();
        t_write_modes();
        t_read_modes();
        t_cfg_frozen();
        t_write_stall();
        t_read_stall();
        t_partial();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, fails);
        $finish;
    end

endmodule